// File: doc/BRIEF.md
# Reserved-Address Command Handler

This block watches a two-wire serial bus from the slave side and services the reserved addresses that a byte-addressed memory target answers besides its normal read and write traffic. It has three functions. It reads out a fixed three-byte identification code. It puts the device into a low-power sleep state through a three-part command. It wakes from sleep, then holds off all bus traffic for a timed regulator recovery. It also notes when a master announces a high-speed transfer and holds that state until the next STOP.

SCL and SDA are synchronised into the system clock domain and turned into edge and START/STOP events. One state machine decodes the bytes and drives SDA low, open-drain style, for acknowledges and ID data. A separate counter times the recovery window. Normal memory commands are outside the block: it leaves them unacknowledged and waits for the next START.

Top module: `rsv_cmd_handler`

## Requirements
- R1: After reset the handler is idle: `sleep_o`=0, `ready_o`=1, `hs_mode_o`=0, `sda_pull_o`=0.
- R2: A byte 0xF8 right after a START is acknowledged. The next byte is also acknowledged when its bits [7:4] equal 4'b1010 and its bits [3:2] equal `dev_sel_i`, whatever bits [1:0] hold. SDA is pulled low on the ninth clock and is driven or released only while SCL is low.
- R3: If that device byte does not match, it gets no acknowledge and the sequence is dropped. A following repeated START with 0xF9 is then not acknowledged.
- R4: After an accepted 0xF8 and device byte, a repeated START with 0xF9 is acknowledged. The handler then sends 0x00, 0xA7 and 0x58, MSB first, each held on `id_byte_o` with a one-cycle `id_load_o` pulse.
- R5: A master ACK after the third ID byte restarts the readout at 0x00. A master NACK ends the readout and leaves SDA released.
- R6: After an accepted 0xF8 and device byte, a repeated START with 0x86 is acknowledged. Sleep starts at the SCL fall that ends that acknowledge: `sleep_o`=1 and `ready_o`=0.
- R7: While asleep, nothing is acknowledged and SDA is never driven. The ninth SCL rising edge after a START ends sleep and starts recovery (`sleep_o`=0, `ready_o`=0).
- R8: Recovery lasts `REC_CYCLES` clock cycles with `ready_o`=0. After that `ready_o`=1, and a new 0xF8 after a START is acknowledged.
- R9: A byte matching 8'b00001xxx right after a START is never acknowledged. It sets `hs_mode_o`, which survives a repeated START and clears on STOP.
- R10: After an accepted 0xF8 and device byte, any byte other than 0xF9 or 0x86 after the repeated START is not acknowledged, and the handler returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_sel_i | input | 2 | Strapped device select value |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| sleep_o | output | 1 | Sleep state |
| ready_o | output | 1 | Neither asleep nor recovering |
| hs_mode_o | output | 1 | High-speed transfer announced, until STOP |
| id_byte_o | output | 8 | ID byte being sent |
| id_load_o | output | 1 | One-cycle pulse when a new ID byte is loaded |

## Verification
Two things happen on the same SCL fall. The acknowledge of the 0x86 command is released, and sleep begins, so both SDA and the sleep flag change together. The bench sends the sleep command and samples one quarter-bit after that fall. It expects SDA released, `sleep_o` high and `ready_o` low all at once. The readout wrap is a second same-edge case: the master ACK of the third byte and the reload of the first byte share one edge. The bench acknowledges byte three and expects 0x00 in the next byte.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DEVW,
    ST_ARMED,
    ST_ACK,
    ST_TX,
    ST_SLEEP,
    ST_RECOVER
  } rsv_state_e;

  localparam logic [7:0] CODE_ID_OPEN = 8'hF8;
  localparam logic [7:0] CODE_ID_READ = 8'hF9;
  localparam logic [7:0] CODE_SLEEP   = 8'h86;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;
  localparam logic [3:0] TYPE_CODE    = 4'b1010;

  function automatic logic [7:0] id_byte(input logic [11:0] mfr,
                                         input logic [11:0] prod,
                                         input logic [1:0]  idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = mfr[11:4];
      2'd1:    b = {mfr[3:0], prod[11:8]};
      default: b = prod[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rsv_line_sync.sv
module rsv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign lvl[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prev_q[0];
  assign scl_fall  = ~lvl[0] & prev_q[0];
  assign bus_start = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
  assign bus_stop  = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];

endmodule

// File: rtl/rsv_recover_timer.sv
module rsv_recover_timer #(
  parameter int CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign done_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // A wake request never arrives while a recovery window is still open (R8)
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

endmodule

// File: rtl/rsv_cmd_fsm.sv
module rsv_cmd_fsm
  import rsv_pkg::*;
#(
  parameter logic [11:0] MFR_CODE  = 12'h00A,
  parameter logic [11:0] PROD_CODE = 12'h758
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [1:0] dev_sel,
  input  logic       rec_done,
  output logic       rec_start,
  output logic       sda_low_o,
  output logic       sleep_o,
  output logic       recovering_o,
  output logic       hs_o,
  output logic [7:0] id_byte_o,
  output logic       id_load_o
);
  localparam int         ID_LEN  = 3;
  localparam logic [1:0] ID_LAST = 2'(ID_LEN - 1);

  rsv_state_e state_q, state_d, ack_next_q, ack_next_d;
  logic [3:0] bit_cnt_q, bit_cnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic [7:0] id_byte_q, id_byte_d;
  logic [1:0] id_idx_q, id_idx_d;
  logic       sda_low_q, sda_low_d;
  logic       armed_q, armed_d;
  logic       hs_q, hs_d;
  logic       wk_arm_q, wk_arm_d;
  logic       id_load_q, id_load_d;
  logic [7:0] cur_byte;
  logic       ack_ok;
  rsv_state_e ack_tgt;

  assign cur_byte = id_byte(MFR_CODE, PROD_CODE, id_idx_q);

  // byte verdict, evaluated when the eighth bit has been shifted in
  always_comb begin
    ack_ok  = 1'b0;
    ack_tgt = ST_IDLE;
    if (state_q == ST_DEVW) begin
      if (shreg_q[7:4] == TYPE_CODE && shreg_q[3:2] == dev_sel) begin
        ack_ok  = 1'b1;
        ack_tgt = ST_ARMED;
      end
    end else if (armed_q) begin
      if (shreg_q == CODE_ID_READ) begin
        ack_ok  = 1'b1;
        ack_tgt = ST_TX;
      end else if (shreg_q == CODE_SLEEP) begin
        ack_ok  = 1'b1;
        ack_tgt = ST_SLEEP;
      end
    end else if (shreg_q == CODE_ID_OPEN) begin
      ack_ok  = 1'b1;
      ack_tgt = ST_DEVW;
    end
  end

  always_comb begin
    state_d    = state_q;
    ack_next_d = ack_next_q;
    bit_cnt_d  = bit_cnt_q;
    shreg_d    = shreg_q;
    id_byte_d  = id_byte_q;
    id_idx_d   = id_idx_q;
    sda_low_d  = sda_low_q;
    armed_d    = armed_q;
    hs_d       = hs_q;
    wk_arm_d   = wk_arm_q;
    id_load_d  = 1'b0;
    rec_start  = 1'b0;
    if (bus_stop) hs_d = 1'b0;

    case (state_q)
      ST_SLEEP: begin
        if (bus_start) begin
          wk_arm_d  = 1'b1;
          bit_cnt_d = '0;
        end else if (bus_stop) begin
          wk_arm_d = 1'b0;
        end else if (scl_rise && wk_arm_q) begin
          if (bit_cnt_q == 4'd8) begin
            rec_start = 1'b1;
            state_d   = ST_RECOVER;
            wk_arm_d  = 1'b0;
            bit_cnt_d = '0;
          end else begin
            bit_cnt_d = bit_cnt_q + 4'd1;
          end
        end
      end
      ST_RECOVER: begin
        if (rec_done) state_d = ST_IDLE;
      end
      default: begin
        if (bus_start) begin
          state_d   = ST_ADDR;
          bit_cnt_d = '0;
          sda_low_d = 1'b0;
          armed_d   = (state_q == ST_ARMED);
        end else if (bus_stop) begin
          state_d   = ST_IDLE;
          sda_low_d = 1'b0;
          armed_d   = 1'b0;
        end else begin
          case (state_q)
            ST_ADDR, ST_DEVW: begin
              if (scl_rise && bit_cnt_q < 4'd8) begin
                shreg_d   = {shreg_q[6:0], sda_lvl};
                bit_cnt_d = bit_cnt_q + 4'd1;
              end else if (scl_fall && bit_cnt_q == 4'd8) begin
                armed_d = 1'b0;
                if (state_q == ST_ADDR && !armed_q && shreg_q[7:3] == HS_PREFIX)
                  hs_d = 1'b1;
                if (ack_ok) begin
                  sda_low_d  = 1'b1;
                  state_d    = ST_ACK;
                  ack_next_d = ack_tgt;
                  id_idx_d   = '0;
                end else begin
                  state_d = ST_IDLE;
                end
              end
            end
            ST_ACK: begin
              if (scl_rise && bit_cnt_q == 4'd8) begin
                bit_cnt_d = 4'd9;
              end else if (scl_fall && bit_cnt_q == 4'd9) begin
                sda_low_d = 1'b0;
                bit_cnt_d = '0;
                state_d   = ack_next_q;
                if (ack_next_q == ST_TX) begin
                  id_byte_d = cur_byte;
                  id_load_d = 1'b1;
                  sda_low_d = ~cur_byte[7];
                end else if (ack_next_q == ST_SLEEP) begin
                  wk_arm_d = 1'b0;
                  hs_d     = 1'b0;
                end
              end
            end
            ST_TX: begin
              if (scl_rise) begin
                if (bit_cnt_q < 4'd8) begin
                  bit_cnt_d = bit_cnt_q + 4'd1;
                end else if (bit_cnt_q == 4'd8) begin
                  if (!sda_lvl) begin
                    bit_cnt_d = 4'd9;
                    id_idx_d  = (id_idx_q == ID_LAST) ? 2'd0 : id_idx_q + 2'd1;
                  end else begin
                    state_d = ST_IDLE;
                  end
                end
              end else if (scl_fall) begin
                if (bit_cnt_q == 4'd9) begin
                  id_byte_d = cur_byte;
                  id_load_d = 1'b1;
                  sda_low_d = ~cur_byte[7];
                  bit_cnt_d = '0;
                end else if (bit_cnt_q == 4'd8) begin
                  sda_low_d = 1'b0;
                end else if (bit_cnt_q != 4'd0) begin
                  sda_low_d = ~id_byte_q[3'd7 - bit_cnt_q[2:0]];
                end
              end
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      id_byte_q  <= '0;
      id_idx_q   <= '0;
      sda_low_q  <= 1'b0;
      armed_q    <= 1'b0;
      hs_q       <= 1'b0;
      wk_arm_q   <= 1'b0;
      id_load_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ack_next_q <= ack_next_d;
      bit_cnt_q  <= bit_cnt_d;
      shreg_q    <= shreg_d;
      id_byte_q  <= id_byte_d;
      id_idx_q   <= id_idx_d;
      sda_low_q  <= sda_low_d;
      armed_q    <= armed_d;
      hs_q       <= hs_d;
      wk_arm_q   <= wk_arm_d;
      id_load_q  <= id_load_d;
    end
  end

  assign sda_low_o    = sda_low_q;
  assign sleep_o      = (state_q == ST_SLEEP);
  assign recovering_o = (state_q == ST_RECOVER);
  assign hs_o         = hs_q;
  assign id_byte_o    = id_byte_q;
  assign id_load_o    = id_load_q;

  // SDA stays released through sleep and recovery (R7)
  p_quiet_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP || state_q == ST_RECOVER) |-> !sda_low_q);

  // the pull-down only moves while SCL is low, or on a START/STOP (R2)
  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_q) |-> (!$past(scl_lvl) || $past(bus_start) || $past(bus_stop)));

  // sleep is entered only as the acknowledge is let go (R6)
  p_sleep_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(sda_low_q));

  // the high-speed flag never outlives a STOP (R9)
  p_hs_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !hs_q);

endmodule

// File: rtl/rsv_cmd_handler.sv
module rsv_cmd_handler #(
  parameter int          SYNC_STAGES = 2,
  parameter int          REC_CYCLES  = 40000,
  parameter logic [11:0] MFR_CODE    = 12'h00A,
  parameter logic [11:0] PROD_CODE   = 12'h758
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel_i,
  output logic       sda_pull_o,
  output logic       sleep_o,
  output logic       ready_o,
  output logic       hs_mode_o,
  output logic [7:0] id_byte_o,
  output logic       id_load_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic rec_start, rec_busy, rec_done, recovering;

  rsv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  rsv_recover_timer #(.CYCLES(REC_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(rec_start),
    .busy_o (rec_busy),
    .done_o (rec_done)
  );

  rsv_cmd_fsm #(.MFR_CODE(MFR_CODE), .PROD_CODE(PROD_CODE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .dev_sel     (dev_sel_i),
    .rec_done    (rec_done),
    .rec_start   (rec_start),
    .sda_low_o   (sda_pull_o),
    .sleep_o     (sleep_o),
    .recovering_o(recovering),
    .hs_o        (hs_mode_o),
    .id_byte_o   (id_byte_o),
    .id_load_o   (id_load_o)
  );

  assign ready_o = ~(sleep_o | recovering);

  // while the recovery window runs the handler reports not ready (R8)
  p_ready_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_busy |-> !ready_o);

endmodule

// File: tb/rsv_cmd_handler_tb.sv
module rsv_cmd_handler_tb;
  localparam int Q   = 10;
  localparam int REC = 300;

  logic clk, rst_n, scl_m, sda_m;
  logic [1:0] dev_sel;
  logic sda_pull, sleep_f, ready_f, hs_f, id_load;
  logic [7:0] id_byte;
  logic sda_bus;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag_q[$];
  int    exp_q[$];
  int    act_q[$];

  assign sda_bus = sda_m & ~sda_pull;

  rsv_cmd_handler #(.REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .dev_sel_i(dev_sel), .sda_pull_o(sda_pull), .sleep_o(sleep_f),
    .ready_o(ready_f), .hs_mode_o(hs_f), .id_byte_o(id_byte), .id_load_o(id_load)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops observed/expected pairs and scores them
  always @(negedge clk) begin
    while (act_q.size() > 0) begin
      string t;
      int e, a;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a != e) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic push(input string t, input int e, input int a);
    tag_q.push_back(t);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  task automatic q_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b0; q_wait(Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic rstart_c();
    sda_m = 1'b1; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    sda_m = 1'b0; q_wait(Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    sda_m = 1'b1; q_wait(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q_wait(Q); scl_m = 1'b1; q_wait(2 * Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    b = sda_bus; q_wait(Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output int acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = (b == 1'b0) ? 1 : 0;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  initial begin
    int ak;
    logic [7:0] rb;
    scl_m = 1'b1; sda_m = 1'b1; dev_sel = 2'b10; rst_n = 1'b0;
    q_wait(5);
    rst_n = 1'b1;
    q_wait(5);
    push("R1 sleep", 0, sleep_f);
    push("R1 ready", 1, ready_f);
    push("R1 hs", 0, hs_f);
    push("R1 sda", 1, sda_bus);

    // ID readout with wrap; device word 0xAB has bits [1:0] = 11
    start_c();
    send_byte(8'hF8, ak); push("R2 F8 ack", 1, ak);
    send_byte(8'hAB, ak); push("R2 dev ack", 1, ak);
    rstart_c();
    send_byte(8'hF9, ak); push("R4 F9 ack", 1, ak);
    recv_byte(rb, 1'b1); push("R4 byte0", 8'h00, rb);
    recv_byte(rb, 1'b1); push("R4 byte1", 8'hA7, rb);
    recv_byte(rb, 1'b1); push("R4 byte2", 8'h58, rb);
    recv_byte(rb, 1'b0); push("R5 wrap byte", 8'h00, rb);
    push("R5 released", 1, sda_bus);
    push("R4 id_byte_o", 8'h00, id_byte);
    stop_c();

    // device select mismatch
    start_c();
    send_byte(8'hF8, ak); push("R3 F8 ack", 1, ak);
    send_byte(8'hA4, ak); push("R3 dev nack", 0, ak);
    rstart_c();
    send_byte(8'hF9, ak); push("R3 F9 nack", 0, ak);
    stop_c();

    // high-speed announcement
    start_c();
    send_byte(8'h0D, ak); push("R9 hs nack", 0, ak);
    push("R9 hs set", 1, hs_f);
    rstart_c();
    push("R9 hs kept", 1, hs_f);
    send_byte(8'hF8, ak); push("R9 F8 in hs", 1, ak);
    stop_c();
    push("R9 hs cleared", 0, hs_f);

    // unexpected byte after the armed repeated START
    start_c();
    send_byte(8'hF8, ak); push("R10 F8 ack", 1, ak);
    send_byte(8'hA8, ak); push("R10 dev ack", 1, ak);
    rstart_c();
    send_byte(8'hA0, ak); push("R10 odd nack", 0, ak);
    rstart_c();
    send_byte(8'hF9, ak); push("R10 disarmed", 0, ak);
    stop_c();

    // sleep entry, wake and recovery
    start_c();
    send_byte(8'hF8, ak); push("R6 F8 ack", 1, ak);
    send_byte(8'hA9, ak); push("R6 dev ack", 1, ak);
    rstart_c();
    send_byte(8'h86, ak); push("R6 sleep ack", 1, ak);
    push("R6 sleep", 1, sleep_f);
    push("R6 ready", 0, ready_f);
    push("R6 released", 1, sda_bus);
    stop_c();
    start_c();
    send_byte(8'hA8, ak); push("R7 no ack asleep", 0, ak);
    push("R7 awake", 0, sleep_f);
    push("R7 recovering", 0, ready_f);
    stop_c();
    q_wait(200 - 4 * Q);
    push("R8 still recovering", 0, ready_f);
    q_wait(150);
    push("R8 ready", 1, ready_f);
    start_c();
    send_byte(8'hF8, ak); push("R8 F8 ack", 1, ak);
    stop_c();

    q_wait(4);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule